// File: doc/BRIEF.md
# Embedded Controller Byte Link Engine

This block is the per-byte protocol engine behind an I2C target byte interface that links an application processor to an embedded controller. Each byte event arrives with four status flags: interrupt, end-of-transfer, address-received and read-not-write. From these flags the engine walks a five-state machine. It assembles incoming messages into receive slots taken from an external slot allocator. When the controller reads, it supplies the bytes of the queued outgoing message. It also drives an active-low request line that asks the controller to come and read.

A transfer opens with an address event and then a command byte. If the command byte is 0x01 and the bus then turns around into a read, the engine transmits the head of the outgoing queue, or a three-byte no-op message when the queue is empty. In every other case the engine keeps receiving. A two-bit length code in the first received byte sets the expected message length. At end-of-transfer, a message whose length matches is committed and one whose length does not match is dropped.

Top module: `ec_link_engine`

## Requirements
- R1: After synchronous reset, req_n is high and resp_valid, addr_mismatch, tx_done, rx_wr_en, rx_commit, rx_drop, rx_free and xfer_done are all low.
- R2: An interrupt event with address-received set and read-not-write clear starts a new transfer from any state. If its byte differs from own_addr, addr_mismatch pulses for one cycle.
- R3: After the address event, a plain interrupt event (only the interrupt flag set) raises rx_alloc_req in the same cycle. If rx_alloc_ok is high, the byte is written at index 0. If the slot is refused, or the status is anything else, the transfer is abandoned and no further bytes are written.
- R4: After a stored command byte of 0x01, the status {interrupt, read-not-write, address-received} returns byte 0 of the queued message, pulses rx_free and raises req_n. With any other command byte, the same status returns 0xFF and starts no transmission.
- R5: Each later read event returns the next message byte. End-of-transfer after all tx_len bytes are sent pulses tx_done. End-of-transfer before that rewinds the message to byte 0, drives req_n low and gives no tx_done.
- R6: When a read begins with tx_pending low, the bytes 0x02, 0x07, 0x02 are sent and tx_done never pulses. A read past the last byte of a message returns 0xFF and ends the transfer.
- R7: Of a received message, the byte after the command is written at index 1 and later bytes at rising indices up to MSG_MAX-1. Bytes beyond MSG_MAX are not written.
- R8: The expected length is byte1+2 when byte0 bit 7 is clear or byte0 bits 6:5 equal 2. It is 2 for code 0 and 3 for code 1. Code 3 never matches. End-of-transfer with read-not-write clear pulses rx_commit on a length match, and otherwise pulses rx_drop together with rx_free.
- R9: xfer_done pulses with rx_commit exactly when byte0 bit 7 is clear.
- R10: resp_valid pulses one cycle after every interrupt event that has read-not-write set and end-of-transfer clear. resp_byte is 0xFF when no message byte is due. End-of-transfer events get no response.
- R11: Events with the interrupt flag clear change nothing and produce no response.
- R12: While the engine is idle and tx_pending is high, req_n is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 8 | Expected address byte |
| ev_valid | input | 1 | Byte event strobe |
| ev_irq | input | 1 | Interrupt flag of the event |
| ev_end | input | 1 | End-of-transfer flag |
| ev_addr | input | 1 | Address-received flag |
| ev_rnw | input | 1 | Read-not-write flag |
| ev_byte | input | 8 | Received byte |
| resp_valid | output | 1 | Response byte strobe |
| resp_byte | output | 8 | Byte to drive to the controller |
| req_n | output | 1 | Active-low read request line |
| addr_mismatch | output | 1 | Address byte differed from own_addr |
| tx_pending | input | 1 | Outgoing queue not empty |
| tx_len | input | POS_W | Length of queued message |
| tx_rd_idx | output | POS_W | Byte index into queued message |
| tx_rd_data | input | 8 | Queued message byte at tx_rd_idx |
| tx_done | output | 1 | Queued message fully sent, pop it |
| rx_alloc_req | output | 1 | Receive slot request (combinational) |
| rx_alloc_ok | input | 1 | Receive slot granted |
| rx_free | output | 1 | Receive slot released unused |
| rx_wr_en | output | 1 | Receive byte write strobe |
| rx_wr_idx | output | POS_W | Receive byte index |
| rx_wr_data | output | 8 | Receive byte value |
| rx_commit | output | 1 | Message complete with correct length |
| rx_drop | output | 1 | Message discarded for wrong length |
| xfer_done | output | 1 | Completed message was a reply |

## Verification
The length decoder is swept over both values of the event bit, all four length codes and several values of byte1, with every message length from 2 to 6 bytes. This separates the fixed-length codes from the variable-length rule and confirms that code 3 never commits. Read transfers run three ways: to completion, cut short by an early end-of-transfer, and against an empty queue. These separate the normal path from the rewind path and the no-op path, and each path is observed on the response bytes and on req_n. Single-fault patterns cover a refused slot, a wrong command byte, a wrong status in the command state, a message longer than the buffer and an event without the interrupt flag; each shows whether the engine abandons a transfer or ignores a stray event.

// File: rtl/ec_link_pkg.sv
package ec_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_FIRST = 3'd2,
        ST_TX    = 3'd3,
        ST_RX    = 3'd4
    } link_state_e;

    typedef struct packed {
        logic irq;
        logic fin;
        logic adr;
        logic rnw;
    } ev_flags_t;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
    localparam logic [7:0] READ_CMD  = 8'h01;
    localparam logic [1:0] LEN_TWO   = 2'd0;
    localparam logic [1:0] LEN_THREE = 2'd1;
    localparam logic [1:0] LEN_VAR   = 2'd2;

    function automatic logic is_open(input ev_flags_t f);
        return f.irq && f.adr && !f.fin && !f.rnw;
    endfunction

    function automatic logic is_plain(input ev_flags_t f);
        return f.irq && !f.adr && !f.fin && !f.rnw;
    endfunction

    function automatic logic is_turn(input ev_flags_t f);
        return f.irq && f.adr && f.rnw && !f.fin;
    endfunction

    function automatic logic [8:0] rx_expected_len(input logic [7:0] b0, input logic [7:0] b1);
        if (!b0[7] || b0[6:5] == LEN_VAR) return {1'b0, b1} + 9'd2;
        if (b0[6:5] == LEN_TWO)           return 9'd2;
        if (b0[6:5] == LEN_THREE)         return 9'd3;
        return 9'd0;
    endfunction

    function automatic logic [7:0] noop_byte(input int unsigned idx);
        case (idx)
            0:       return 8'h02;
            1:       return 8'h07;
            2:       return 8'h02;
            default: return FILL_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/ec_link_rx_track.sv
module ec_link_rx_track
    import ec_link_pkg::*;
#(
    parameter int MSG_MAX = 32,
    parameter int POS_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_cmd,
    input  logic             take_len,
    input  logic             take_body,
    input  logic [7:0]       din,
    output logic [7:0]       cmd_byte,
    output logic             is_event,
    output logic             len_ok,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    localparam int CMP_W = (POS_W > 9) ? POS_W : 9;
    localparam logic [POS_W-1:0] MAX_POS = POS_W'(MSG_MAX);

    logic [7:0]       b1_q;
    logic [POS_W-1:0] pos_q;
    logic             room;

    assign room     = pos_q < MAX_POS;
    assign is_event = cmd_byte[7];
    assign len_ok   = CMP_W'(pos_q) == CMP_W'(rx_expected_len(cmd_byte, b1_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_byte <= '0;
            b1_q     <= '0;
            pos_q    <= '0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en   <= take_cmd || take_len || (take_body && room);
            wr_data <= din;
            if (take_cmd) begin
                cmd_byte <= din;
                pos_q    <= POS_W'(1);
                wr_idx   <= '0;
            end else if (take_len) begin
                b1_q   <= din;
                pos_q  <= POS_W'(2);
                wr_idx <= POS_W'(1);
            end else if (take_body && room) begin
                pos_q  <= pos_q + POS_W'(1);
                wr_idx <= pos_q;
            end
        end
    end
endmodule

// File: rtl/ec_link_tx_cursor.sv
module ec_link_tx_cursor
    import ec_link_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             advance,
    input  logic             rewind,
    input  logic             q_pending,
    input  logic [POS_W-1:0] q_len,
    input  logic [7:0]       q_data,
    output logic [POS_W-1:0] rd_idx,
    output logic [7:0]       cur_byte,
    output logic             more,
    output logic             done_all,
    output logic             using_noop
);
    logic             sel_noop;
    logic [POS_W-1:0] len;

    assign sel_noop = load ? !q_pending : using_noop;
    assign len      = sel_noop ? POS_W'(3) : q_len;
    assign cur_byte = sel_noop ? noop_byte(int'(rd_idx)) : q_data;
    assign more     = rd_idx < len;
    assign done_all = rd_idx == len;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx     <= '0;
            using_noop <= 1'b0;
        end else if (load) begin
            using_noop <= !q_pending;
            rd_idx     <= POS_W'(1);
        end else if (advance) begin
            rd_idx <= rd_idx + POS_W'(1);
        end else if (rewind) begin
            rd_idx <= '0;
        end
    end
endmodule

// File: rtl/ec_link_engine.sv
module ec_link_engine
    import ec_link_pkg::*;
#(
    parameter int MSG_MAX = 32,
    localparam int POS_W = $clog2(MSG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       own_addr,
    input  logic             ev_valid,
    input  logic             ev_irq,
    input  logic             ev_end,
    input  logic             ev_addr,
    input  logic             ev_rnw,
    input  logic [7:0]       ev_byte,
    output logic             resp_valid,
    output logic [7:0]       resp_byte,
    output logic             req_n,
    output logic             addr_mismatch,
    input  logic             tx_pending,
    input  logic [POS_W-1:0] tx_len,
    output logic [POS_W-1:0] tx_rd_idx,
    input  logic [7:0]       tx_rd_data,
    output logic             tx_done,
    output logic             rx_alloc_req,
    input  logic             rx_alloc_ok,
    output logic             rx_free,
    output logic             rx_wr_en,
    output logic [POS_W-1:0] rx_wr_idx,
    output logic [7:0]       rx_wr_data,
    output logic             rx_commit,
    output logic             rx_drop,
    output logic             xfer_done
);
    ev_flags_t   f;
    link_state_e state, nxt, cur_st;
    logic        fire, holding;
    logic        take_cmd, take_len, take_body;
    logic        tx_load, tx_adv, tx_rew;
    logic        do_commit, do_drop, do_xfer, do_txfin, req_hi, req_lo;
    logic [7:0]  to_send, cmd_byte, cur_byte;
    logic        is_event, len_ok, more, done_all, using_noop;

    assign f       = '{irq: ev_irq, fin: ev_end, adr: ev_addr, rnw: ev_rnw};
    assign fire    = ev_valid && ev_irq;
    assign holding = (state == ST_FIRST) || (state == ST_RX);

    ec_link_rx_track #(.MSG_MAX(MSG_MAX), .POS_W(POS_W)) rx_i (
        .clk(clk), .rst(rst),
        .take_cmd(take_cmd), .take_len(take_len), .take_body(take_body),
        .din(ev_byte), .cmd_byte(cmd_byte), .is_event(is_event), .len_ok(len_ok),
        .wr_en(rx_wr_en), .wr_idx(rx_wr_idx), .wr_data(rx_wr_data)
    );

    ec_link_tx_cursor #(.POS_W(POS_W)) tx_i (
        .clk(clk), .rst(rst),
        .load(tx_load), .advance(tx_adv), .rewind(tx_rew || (fire && nxt != ST_TX)),
        .q_pending(tx_pending), .q_len(tx_len), .q_data(tx_rd_data),
        .rd_idx(tx_rd_idx), .cur_byte(cur_byte), .more(more),
        .done_all(done_all), .using_noop(using_noop)
    );

    always_comb begin
        nxt = state;  cur_st = state;  to_send = FILL_BYTE;
        take_cmd = 1'b0;  take_len = 1'b0;  take_body = 1'b0;  rx_alloc_req = 1'b0;
        tx_load = 1'b0;  tx_adv = 1'b0;  tx_rew = 1'b0;
        do_commit = 1'b0;  do_drop = 1'b0;  do_xfer = 1'b0;  do_txfin = 1'b0;
        req_hi = 1'b0;  req_lo = 1'b0;
        if (fire) begin
            cur_st = is_open(f) ? ST_IDLE : state;
            nxt    = cur_st;
            unique case (cur_st)
                ST_IDLE: ;
                ST_CMD: begin
                    nxt = ST_IDLE;
                    if (is_plain(f)) begin
                        rx_alloc_req = 1'b1;
                        if (rx_alloc_ok) begin
                            take_cmd = 1'b1;
                            nxt      = ST_FIRST;
                        end
                    end
                end
                ST_FIRST: begin
                    nxt = ST_IDLE;
                    if (is_turn(f)) begin
                        if (cmd_byte == READ_CMD) begin
                            tx_load = 1'b1;
                            to_send = cur_byte;
                            req_hi  = 1'b1;
                            nxt     = ST_TX;
                        end
                    end else if (is_plain(f)) begin
                        take_len = 1'b1;
                        nxt      = ST_RX;
                    end
                end
                ST_TX: begin
                    if (f.fin) begin
                        if (done_all) begin
                            nxt      = ST_IDLE;
                            do_txfin = !using_noop;
                        end else begin
                            tx_rew = 1'b1;
                            req_lo = 1'b1;
                        end
                    end else if (!f.rnw || f.adr) begin
                        nxt = ST_IDLE;
                    end else if (more) begin
                        to_send = cur_byte;
                        tx_adv  = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_RX: begin
                    if (f.fin && !f.rnw) begin
                        nxt       = ST_IDLE;
                        do_commit = len_ok;
                        do_drop   = !len_ok;
                        do_xfer   = len_ok && !is_event;
                    end else if (f.rnw || f.adr) begin
                        nxt = ST_IDLE;
                    end else begin
                        take_body = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
            if (f.adr && !f.rnw) nxt = ST_CMD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            req_n         <= 1'b1;
            resp_valid    <= 1'b0;
            resp_byte     <= FILL_BYTE;
            addr_mismatch <= 1'b0;
            tx_done       <= 1'b0;
            rx_free       <= 1'b0;
            rx_commit     <= 1'b0;
            rx_drop       <= 1'b0;
            xfer_done     <= 1'b0;
        end else begin
            if (fire) state <= nxt;
            if (req_hi)                                 req_n <= 1'b1;
            else if (req_lo)                            req_n <= 1'b0;
            else if (state == ST_IDLE && tx_pending)    req_n <= 1'b0;
            resp_valid    <= fire && f.rnw && !f.fin;
            resp_byte     <= to_send;
            addr_mismatch <= fire && f.adr && !f.rnw && (ev_byte != own_addr);
            tx_done       <= do_txfin;
            rx_commit     <= do_commit;
            rx_drop       <= do_drop;
            xfer_done     <= do_xfer;
            rx_free       <= fire && holding && !do_commit && (nxt != ST_FIRST) && (nxt != ST_RX);
        end
    end
endmodule

// File: rtl/ec_link_engine_chk.sv
module ec_link_engine_chk
    import ec_link_pkg::*;
#(
    parameter int MSG_MAX = 32,
    parameter int POS_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input link_state_e      state,
    input logic             ev_valid,
    input logic             ev_irq,
    input logic             ev_end,
    input logic             ev_addr,
    input logic             ev_rnw,
    input logic             resp_valid,
    input logic             req_n,
    input logic             addr_mismatch,
    input logic             rx_alloc_req,
    input logic             rx_free,
    input logic             rx_wr_en,
    input logic [POS_W-1:0] rx_wr_idx,
    input logic             rx_commit,
    input logic             rx_drop,
    input logic             xfer_done
);
    localparam logic [POS_W-1:0] MAX_POS = POS_W'(MSG_MAX);

    p_alloc_in_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        rx_alloc_req |-> (ev_valid && ev_irq && state == ST_CMD));

    p_resp_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(ev_valid && ev_irq && ev_rnw && !ev_end));

    p_outcome_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_commit, rx_drop}) && !(rx_commit && rx_free));

    p_drop_frees_r8: assert property (@(posedge clk) disable iff (rst)
        rx_drop |-> rx_free);

    p_xfer_commit_r9: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> rx_commit);

    p_req_release_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(req_n) |-> resp_valid);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        rx_wr_en |-> rx_wr_idx < MAX_POS);

    p_mismatch_src_r2: assert property (@(posedge clk) disable iff (rst)
        addr_mismatch |-> $past(ev_valid && ev_irq && ev_addr && !ev_rnw));
endmodule

bind ec_link_engine ec_link_engine_chk #(.MSG_MAX(MSG_MAX), .POS_W(POS_W)) chk_i (
    .clk(clk), .rst(rst), .state(state),
    .ev_valid(ev_valid), .ev_irq(ev_irq), .ev_end(ev_end), .ev_addr(ev_addr), .ev_rnw(ev_rnw),
    .resp_valid(resp_valid), .req_n(req_n), .addr_mismatch(addr_mismatch),
    .rx_alloc_req(rx_alloc_req), .rx_free(rx_free), .rx_wr_en(rx_wr_en), .rx_wr_idx(rx_wr_idx),
    .rx_commit(rx_commit), .rx_drop(rx_drop), .xfer_done(xfer_done)
);

// File: tb/ec_link_engine_tb_top.sv
module ec_link_engine_tb_top;
    localparam int MSG_MAX = 32;
    localparam int POS_W   = $clog2(MSG_MAX + 1);
    localparam logic [7:0] OWN = 8'h8A;

    logic clk = 1'b0, rst = 1'b1;
    logic ev_valid = 0, ev_irq = 0, ev_end = 0, ev_addr = 0, ev_rnw = 0;
    logic [7:0] ev_byte = '0;
    logic resp_valid, req_n, addr_mismatch, tx_done, rx_alloc_req, rx_free, rx_wr_en;
    logic rx_commit, rx_drop, xfer_done;
    logic [7:0] resp_byte, rx_wr_data, tx_rd_data;
    logic [POS_W-1:0] tx_rd_idx, rx_wr_idx;
    logic tx_pending = 1'b0, rx_alloc_ok = 1'b1;
    logic [POS_W-1:0] tx_len = '0;
    logic [7:0] tx_msg [0:7];
    logic [7:0] buf_b [0:63];

    int n_checks = 0, n_errors = 0;
    int n_wr = 0, n_commit = 0, n_drop = 0, n_free = 0, n_xfer = 0, n_txdone = 0, n_mis = 0, n_resp = 0;
    int wr_idx_log [0:63];
    logic [7:0] wr_dat_log [0:63];
    logic [7:0] resp_log [0:63];
    bit finished = 0;

    always #5 clk = ~clk;
    assign tx_rd_data = tx_msg[tx_rd_idx[2:0]];

    ec_link_engine #(.MSG_MAX(MSG_MAX)) dut_i (
        .clk(clk), .rst(rst), .own_addr(OWN),
        .ev_valid(ev_valid), .ev_irq(ev_irq), .ev_end(ev_end), .ev_addr(ev_addr), .ev_rnw(ev_rnw),
        .ev_byte(ev_byte), .resp_valid(resp_valid), .resp_byte(resp_byte), .req_n(req_n),
        .addr_mismatch(addr_mismatch), .tx_pending(tx_pending), .tx_len(tx_len),
        .tx_rd_idx(tx_rd_idx), .tx_rd_data(tx_rd_data), .tx_done(tx_done),
        .rx_alloc_req(rx_alloc_req), .rx_alloc_ok(rx_alloc_ok), .rx_free(rx_free),
        .rx_wr_en(rx_wr_en), .rx_wr_idx(rx_wr_idx), .rx_wr_data(rx_wr_data),
        .rx_commit(rx_commit), .rx_drop(rx_drop), .xfer_done(xfer_done)
    );

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (rx_wr_en) begin
                if (n_wr < 64) begin
                    wr_idx_log[n_wr] = int'(rx_wr_idx);
                    wr_dat_log[n_wr] = rx_wr_data;
                end
                n_wr++;
            end
            if (resp_valid) begin
                if (n_resp < 64) resp_log[n_resp] = resp_byte;
                n_resp++;
            end
            n_commit += int'(rx_commit);
            n_drop   += int'(rx_drop);
            n_free   += int'(rx_free);
            n_xfer   += int'(xfer_done);
            n_mis    += int'(addr_mismatch);
            n_txdone += int'(tx_done);
            if (tx_done) tx_pending = 1'b0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_wr = 0; n_commit = 0; n_drop = 0; n_free = 0; n_xfer = 0;
        n_txdone = 0; n_mis = 0; n_resp = 0;
    endtask

    task automatic ev(input bit i, input bit e, input bit a, input bit r, input logic [7:0] b);
        @(negedge clk);
        ev_valid = 1'b1; ev_irq = i; ev_end = e; ev_addr = a; ev_rnw = r; ev_byte = b;
        @(negedge clk);
        ev_valid = 1'b0; ev_irq = 0; ev_end = 0; ev_addr = 0; ev_rnw = 0;
    endtask

    task automatic write_xfer(input int n);
        ev(1, 0, 1, 0, OWN);
        for (int k = 0; k < n; k++) ev(1, 0, 0, 0, buf_b[k]);
        ev(1, 1, 0, 0, 8'h00);
    endtask

    task automatic read_open(input logic [7:0] cmd);
        ev(1, 0, 1, 0, OWN);
        ev(1, 0, 0, 0, cmd);
        ev(1, 0, 1, 1, OWN | 8'h01);
    endtask

    task automatic load_msg();
        tx_msg[0] = 8'h03; tx_msg[1] = 8'hA1; tx_msg[2] = 8'hB2; tx_msg[3] = 8'hC3;
        tx_len = POS_W'(4);
        tx_pending = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) tx_msg[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 req_n", int'(req_n), 1);
        check("R1 resp_valid", int'(resp_valid), 0);
        check("R1 pulses", int'(tx_done | rx_commit | rx_drop | rx_free | xfer_done | rx_wr_en | addr_mismatch), 0);

        // R8 R9 R7 length sweep
        for (int hi = 0; hi < 2; hi++)
            for (int code = 0; code < 4; code++)
                for (int b1 = 0; b1 < 4; b1++)
                    for (int n = 2; n <= 6; n++) begin
                        int exp_len, bad;
                        bit ok;
                        buf_b[0] = 8'((hi << 7) | (code << 5) | 3);
                        buf_b[1] = 8'(b1);
                        for (int k = 2; k < n; k++) buf_b[k] = 8'(16 * k + n);
                        if (hi == 0 || code == 2) exp_len = b1 + 2;
                        else if (code == 0) exp_len = 2;
                        else if (code == 1) exp_len = 3;
                        else exp_len = -1;
                        ok = (n == exp_len);
                        clear_logs();
                        write_xfer(n);
                        check("R8 commit", n_commit, int'(ok));
                        check("R8 drop", n_drop, int'(!ok));
                        check("R8 free on drop", n_free, int'(!ok));
                        check("R9 xfer_done", n_xfer, int'(ok && hi == 0));
                        check("R7 write count", n_wr, n);
                        bad = 0;
                        for (int k = 0; k < n; k++)
                            if (wr_idx_log[k] != k || wr_dat_log[k] != buf_b[k]) bad++;
                        check("R7 write contents", bad, 0);
                        check("R2 no mismatch", n_mis, 0);
                    end

        // R2 address mismatch
        clear_logs();
        ev(1, 0, 1, 0, 8'h55);
        check("R2 mismatch pulse", n_mis, 1);

        // R11 event without interrupt flag inside a receive
        clear_logs();
        buf_b[0] = 8'h02; buf_b[1] = 8'h01; buf_b[2] = 8'h44;
        ev(1, 0, 1, 0, OWN);
        ev(1, 0, 0, 0, buf_b[0]);
        ev(1, 0, 0, 0, buf_b[1]);
        ev(0, 1, 0, 0, 8'h00);
        ev(0, 0, 0, 1, 8'h00);
        ev(1, 0, 0, 0, buf_b[2]);
        ev(1, 1, 0, 0, 8'h00);
        check("R11 commit despite stray", n_commit, 1);
        check("R11 no response", n_resp, 0);

        // R12 R4 R5 R10 full read
        load_msg();
        repeat (2) @(negedge clk);
        check("R12 req low", int'(req_n), 0);
        clear_logs();
        read_open(8'h01);
        check("R4 req released", int'(req_n), 1);
        check("R4 slot freed", n_free, 1);
        for (int k = 0; k < 3; k++) ev(1, 0, 0, 1, 8'h00);
        ev(1, 1, 0, 1, 8'h00);
        check("R10 response count", n_resp, 4);
        check("R5 byte0", int'(resp_log[0]), 8'h03);
        check("R5 byte1", int'(resp_log[1]), 8'hA1);
        check("R5 byte3", int'(resp_log[3]), 8'hC3);
        check("R5 tx_done", n_txdone, 1);
        repeat (2) @(negedge clk);
        check("R12 stays high when empty", int'(req_n), 1);

        // R5 premature end then retry
        load_msg();
        repeat (2) @(negedge clk);
        clear_logs();
        read_open(8'h01);
        ev(1, 0, 0, 1, 8'h00);
        ev(1, 1, 0, 1, 8'h00);
        @(negedge clk);
        check("R5 early end req low", int'(req_n), 0);
        check("R5 early end no done", n_txdone, 0);
        clear_logs();
        read_open(8'h01);
        for (int k = 0; k < 3; k++) ev(1, 0, 0, 1, 8'h00);
        ev(1, 1, 0, 1, 8'h00);
        check("R5 retry from byte0", int'(resp_log[0]), 8'h03);
        check("R5 retry done", n_txdone, 1);

        // R6 no-op on empty queue, underflow
        clear_logs();
        read_open(8'h01);
        for (int k = 0; k < 3; k++) ev(1, 0, 0, 1, 8'h00);
        ev(1, 1, 0, 1, 8'h00);
        check("R6 noop b0", int'(resp_log[0]), 8'h02);
        check("R6 noop b1", int'(resp_log[1]), 8'h07);
        check("R6 noop b2", int'(resp_log[2]), 8'h02);
        check("R6 underflow fill", int'(resp_log[3]), 8'hFF);
        check("R6 no tx_done", n_txdone, 0);

        // R4 wrong command byte
        clear_logs();
        read_open(8'h05);
        ev(1, 0, 0, 1, 8'h00);
        check("R4 wrong cmd fill", int'(resp_log[0]), 8'hFF);
        check("R10 idle read fill", int'(resp_log[1]), 8'hFF);
        check("R4 wrong cmd frees", n_free, 1);
        check("R4 wrong cmd req", int'(req_n), 1);

        // R3 slot refused
        clear_logs();
        rx_alloc_ok = 1'b0;
        buf_b[0] = 8'h80; buf_b[1] = 8'h00;
        write_xfer(2);
        rx_alloc_ok = 1'b1;
        check("R3 refused no writes", n_wr, 0);
        check("R3 refused no outcome", n_commit + n_drop, 0);

        // R3 wrong status in command state
        clear_logs();
        ev(1, 0, 1, 0, OWN);
        ev(1, 0, 0, 1, 8'h80);
        ev(1, 0, 0, 0, 8'h80);
        ev(1, 0, 0, 0, 8'h00);
        ev(1, 1, 0, 0, 8'h00);
        check("R3 bad status no writes", n_wr, 0);
        check("R3 bad status no commit", n_commit, 0);

        // R7 overflow
        clear_logs();
        buf_b[0] = 8'h02; buf_b[1] = 8'd200;
        for (int k = 2; k < MSG_MAX + 3; k++) buf_b[k] = 8'(k);
        write_xfer(MSG_MAX + 3);
        check("R7 writes capped", n_wr, MSG_MAX);
        check("R7 last index", wr_idx_log[MSG_MAX - 1], MSG_MAX - 1);
        check("R8 overflow dropped", n_drop, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule